// File: doc/BRIEF.md
# Multi-mode timer output compare channel

This block is one output-compare channel placed beside a free-running timer that lives elsewhere. It watches the timer count and drives a single output pin. Each cycle it compares the count with a primary and a secondary compare value. A 3-bit mode word picks one of eight waveform behaviours: off, three one-shot shapes, toggle, repeating pulse, and two pulse-width modulation variants. One of the PWM variants adds fault shutdown.

Each mode has its own starting pin level, loaded on the clock after the mode word changes. Each mode also has its own rule for which pin transitions raise the one-cycle interrupt. In the PWM modes the channel asks the timer to restart on a period match. At each period start it loads the secondary value into its active duty register. A low level on the fault input, in the protected PWM mode, drives the pin low and sets a flag that holds until the mode word changes. Compare and period events are acted on only while the timer-enable input is high.

Top module: `oc_channel`

## Requirements
- R1: With mode 000 the pin equals `gpio_level` in the same cycle, and `irq` stays low.
- R2: On the clock after `mode_sel` differs from the active mode, the pin takes the new mode's starting level. That level is 0 for 001, 100 and 101, and 1 for 010. For 011 it is the pin level shown just before. For 110 and 111 it is 1 if `cmp_pri` is non-zero and 0 otherwise. The same clock clears the fault flag and raises no interrupt.
- R3: Mode 001: the pin rises on the first enabled cycle with `tmr_cnt == cmp_pri` and never changes again. `irq` is high for the one cycle in which the new level first shows.
- R4: Mode 010: the pin falls on the first enabled primary match and never changes again. `irq` pulses with the fall.
- R5: Mode 011: every enabled primary match inverts the pin, and each inversion, rising or falling, pulses `irq`.
- R6: Mode 100: the pin rises at a primary match and later falls at a secondary match, once only. Only the fall pulses `irq`.
- R7: Mode 101: the rise at the primary match and the fall at the secondary match repeat without limit. Each fall pulses `irq`.
- R8: Modes 110 and 111: `tmr_clr` equals `tmr_period_hit`, and in every other mode it is 0. On an enabled period hit, `cmp_sec` is loaded as the active duty and the pin becomes 1 if `cmp_sec` is non-zero. An enabled count equal to the active duty clears the pin. Mode 110 never raises `irq`.
- R9: Mode 111: a low `fault_n` forces the pin to 0 and sets `fault_flag` on the next clock. Both hold until the mode changes. `irq` pulses once for each high-to-low step of `fault_n`.
- R10: While `tmr_en` is low, compare matches and period hits do not change the pin or raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Timer running; gates compare and period events |
| tmr_cnt | input | CNT_W | Timer count |
| tmr_period_hit | input | 1 | One-cycle timer period match |
| cmp_pri | input | CNT_W | Primary compare value |
| cmp_sec | input | CNT_W | Secondary compare value |
| mode_sel | input | 3 | Waveform mode word |
| gpio_level | input | 1 | Pin level used while the channel is off |
| fault_n | input | 1 | Active-low fault request |
| pin_out | output | 1 | Output pin level |
| irq | output | 1 | One-cycle interrupt pulse |
| tmr_clr | output | 1 | Timer restart request in PWM modes |
| fault_flag | output | 1 | Sticky fault indication |

## Verification
The assertions check several rules on every cycle. The off mode must pass the GPIO level through and stay silent. A fresh mode must start at its set level. The restart request may appear only in PWM modes, and mode 110 must never interrupt. A latched fault must keep the pin low, a stopped timer must freeze the pin, and interrupts in the edge-driven modes must line up with real pin changes. Only the bench scenarios can show the order of events within a mode. Examples are the one-shot firing once, the delayed pulse rising before it falls, the continuous pulse repeating, and the duty value being taken at period start. A bench model follows random mode, count and fault sequences to confirm these.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;

  typedef enum logic [2:0] {
    OCM_OFF   = 3'd0,
    OCM_OS_LO = 3'd1,
    OCM_OS_HI = 3'd2,
    OCM_TOG   = 3'd3,
    OCM_DLY   = 3'd4,
    OCM_CONT  = 3'd5,
    OCM_PWM   = 3'd6,
    OCM_PWMF  = 3'd7
  } ocm_e;

  localparam int NREF = 3;  // primary, secondary, active duty

  function automatic logic is_pwm(ocm_e m);
    return (m == OCM_PWM) || (m == OCM_PWMF);
  endfunction

  // Level loaded when a mode is entered.
  function automatic logic entry_level(ocm_e m, logic pri_nz, logic cur, logic held);
    logic lv;
    case (m)
      OCM_OS_HI:          lv = 1'b1;
      OCM_TOG:            lv = cur;
      OCM_PWM, OCM_PWMF:  lv = pri_nz;
      OCM_OFF:            lv = held;
      default:            lv = 1'b0;
    endcase
    return lv;
  endfunction

  // Which pin transitions raise the interrupt in edge-driven modes.
  function automatic logic edge_irq(ocm_e m, logic rise, logic fall);
    logic v;
    case (m)
      OCM_OS_LO:          v = rise;
      OCM_OS_HI:          v = fall;
      OCM_TOG:            v = rise | fall;
      OCM_DLY, OCM_CONT:  v = fall;
      default:            v = 1'b0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/oc_match.sv
`timescale 1ns/1ps
module oc_match
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            en,
  input  logic [W-1:0]    cnt,
  input  logic [W-1:0]    ref_pri,
  input  logic [W-1:0]    ref_sec,
  input  logic [W-1:0]    ref_duty,
  output logic [NREF-1:0] hits
);
  logic [W-1:0] refs [NREF];

  assign refs[0] = ref_pri;
  assign refs[1] = ref_sec;
  assign refs[2] = ref_duty;

  for (genvar g = 0; g < NREF; g++) begin : g_cmp
    assign hits[g] = en & (cnt == refs[g]);
  end
endmodule

// File: rtl/oc_wave.sv
`timescale 1ns/1ps
module oc_wave
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ocm_e         mode,
  input  logic         en,
  input  logic         period_hit,
  input  logic         fault_n,
  input  logic [W-1:0] cmp_pri,
  input  logic [W-1:0] cmp_sec,
  input  logic         hit_pri,
  input  logic         hit_sec,
  input  logic         hit_duty,
  input  logic         cur_out,
  output ocm_e         mode_q,
  output logic         pin_q,
  output logic [W-1:0] duty_q,
  output logic         flt_q,
  output logic         mode_stable,
  output logic         rise_evt,
  output logic         fall_evt
);
  logic         pin_d, done_q, done_d, flt_d;
  logic [W-1:0] duty_d;
  logic         per_en;

  assign mode_stable = (mode == mode_q);
  assign per_en      = en & period_hit;

  always_comb begin
    pin_d  = pin_q;
    done_d = done_q;
    flt_d  = flt_q;
    duty_d = duty_q;
    if (!mode_stable) begin
      pin_d  = entry_level(mode, |cmp_pri, cur_out, pin_q);
      done_d = 1'b0;
      flt_d  = 1'b0;
      duty_d = cmp_pri;
    end else begin
      case (mode_q)
        OCM_OS_LO: if (hit_pri && !done_q) begin pin_d = 1'b1; done_d = 1'b1; end
        OCM_OS_HI: if (hit_pri && !done_q) begin pin_d = 1'b0; done_d = 1'b1; end
        OCM_TOG:   if (hit_pri) pin_d = ~pin_q;
        OCM_DLY, OCM_CONT: begin
          if (!pin_q && hit_pri && !done_q) pin_d = 1'b1;
          else if (pin_q && hit_sec) begin
            pin_d  = 1'b0;
            done_d = (mode_q == OCM_DLY);
          end
        end
        OCM_PWM, OCM_PWMF: begin
          if (per_en) begin
            duty_d = cmp_sec;
            pin_d  = |cmp_sec;
          end else if (hit_duty) begin
            pin_d = 1'b0;
          end
          if (mode_q == OCM_PWMF) begin
            if (!fault_n) flt_d = 1'b1;
            if (flt_d) pin_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign rise_evt = mode_stable & ~pin_q & pin_d;
  assign fall_evt = mode_stable & pin_q & ~pin_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= OCM_OFF;
      pin_q  <= 1'b0;
      done_q <= 1'b0;
      flt_q  <= 1'b0;
      duty_q <= '0;
    end else begin
      mode_q <= mode;
      pin_q  <= pin_d;
      done_q <= done_d;
      flt_q  <= flt_d;
      duty_q <= duty_d;
    end
  end
endmodule

// File: rtl/oc_irq.sv
`timescale 1ns/1ps
module oc_irq
  import oc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ocm_e mode_q,
  input  logic mode_stable,
  input  logic rise_evt,
  input  logic fall_evt,
  input  logic fault_n,
  output logic irq
);
  logic fault_q, flt_fall, irq_d;

  assign flt_fall = fault_q & ~fault_n;
  assign irq_d    = mode_stable &
                    ((mode_q == OCM_PWMF) ? flt_fall : edge_irq(mode_q, rise_evt, fall_evt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b1;
      irq     <= 1'b0;
    end else begin
      fault_q <= fault_n;
      irq     <= irq_d;
    end
  end
endmodule

// File: rtl/oc_channel.sv
`timescale 1ns/1ps
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic             tmr_period_hit,
  input  logic [CNT_W-1:0] cmp_pri,
  input  logic [CNT_W-1:0] cmp_sec,
  input  logic [2:0]       mode_sel,
  input  logic             gpio_level,
  input  logic             fault_n,
  output logic             pin_out,
  output logic             irq,
  output logic             tmr_clr,
  output logic             fault_flag
);
  ocm_e             mode_req, mode_act;
  logic             pin_q, flt_q, mode_stable, rise_evt, fall_evt;
  logic [CNT_W-1:0] duty_q;
  logic [NREF-1:0]  hits;

  assign mode_req = ocm_e'(mode_sel);

  oc_match #(.W(CNT_W)) u_match (
    .en(tmr_en), .cnt(tmr_cnt), .ref_pri(cmp_pri), .ref_sec(cmp_sec),
    .ref_duty(duty_q), .hits(hits)
  );

  oc_wave #(.W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .mode(mode_req), .en(tmr_en),
    .period_hit(tmr_period_hit), .fault_n(fault_n),
    .cmp_pri(cmp_pri), .cmp_sec(cmp_sec),
    .hit_pri(hits[0]), .hit_sec(hits[1]), .hit_duty(hits[2]),
    .cur_out(pin_out), .mode_q(mode_act), .pin_q(pin_q), .duty_q(duty_q),
    .flt_q(flt_q), .mode_stable(mode_stable), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  oc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_act), .mode_stable(mode_stable),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .fault_n(fault_n), .irq(irq)
  );

  assign pin_out    = (mode_act == OCM_OFF) ? gpio_level : pin_q;
  assign tmr_clr    = is_pwm(mode_act) & tmr_period_hit;
  assign fault_flag = flt_q;
endmodule

// File: rtl/oc_channel_chk.sv
`timescale 1ns/1ps
module oc_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_sel,
  input logic [2:0] mode_act,
  input logic       tmr_en,
  input logic       gpio_level,
  input logic       pin_out,
  input logic       irq,
  input logic       tmr_clr,
  input logic       fault_flag
);
  p_off_gpio_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 3'd0) |-> (pin_out == gpio_level));

  p_off_noirq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 3'd0) |-> !irq);

  p_entry_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel != mode_act) && (mode_sel == 3'd1 || mode_sel == 3'd4 || mode_sel == 3'd5))
    |=> (pin_out == 1'b0));

  p_entry_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel != mode_act) && (mode_sel == 3'd2)) |=> (pin_out == 1'b1));

  p_entry_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != mode_act) |=> (!irq && !fault_flag));

  p_irq_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && mode_act >= 3'd1 && mode_act <= 3'd5) |-> (pin_out != $past(pin_out)));

  p_clr_pwm_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |-> (mode_act[2:1] == 2'b11));

  p_pwm_noirq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 3'd6) |-> !irq);

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 3'd7 && fault_flag) |-> !pin_out);

  p_stopped_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && mode_sel == mode_act && mode_act >= 3'd1 && mode_act <= 3'd6)
    |=> ($stable(pin_out) && !irq));
endmodule

bind oc_channel oc_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mode_act(mode_act),
  .tmr_en(tmr_en), .gpio_level(gpio_level), .pin_out(pin_out), .irq(irq),
  .tmr_clr(tmr_clr), .fault_flag(fault_flag)
);

// File: tb/oc_channel_test.sv
`timescale 1ns/1ps
module oc_channel_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n, tmr_en, tmr_period_hit, gpio_level, fault_n;
  logic [W-1:0] tmr_cnt, cmp_pri, cmp_sec;
  logic [2:0] mode_sel;
  logic pin_out, irq, tmr_clr, fault_flag;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;  // 250 MHz

  oc_channel #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .tmr_cnt(tmr_cnt),
    .tmr_period_hit(tmr_period_hit), .cmp_pri(cmp_pri), .cmp_sec(cmp_sec),
    .mode_sel(mode_sel), .gpio_level(gpio_level), .fault_n(fault_n),
    .pin_out(pin_out), .irq(irq), .tmr_clr(tmr_clr), .fault_flag(fault_flag)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Reference state, kept from the requirements.
  logic [2:0]   m_mode;
  logic         m_pin, m_done, m_flt, m_fq, m_irq;
  logic [W-1:0] m_duty;

  task automatic mdl_reset();
    m_mode = 3'd0; m_pin = 1'b0; m_done = 1'b0; m_flt = 1'b0;
    m_fq = 1'b1; m_irq = 1'b0; m_duty = '0;
  endtask

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic mdl_edge();
    logic nxt, ir, ffall;
    ffall = m_fq && !fault_n;
    m_fq  = fault_n;
    ir    = 1'b0;
    if (mode_sel != m_mode) begin
      case (mode_sel)
        3'd0: nxt = m_pin;
        3'd2: nxt = 1'b1;
        3'd3: nxt = (m_mode == 3'd0) ? gpio_level : m_pin;
        3'd6, 3'd7: nxt = (cmp_pri != 0);
        default: nxt = 1'b0;
      endcase
      m_done = 1'b0; m_flt = 1'b0; m_duty = cmp_pri; m_mode = mode_sel;
    end else begin
      nxt = m_pin;
      if (tmr_en) begin
        case (m_mode)
          3'd1: if (tmr_cnt == cmp_pri && !m_done) begin nxt = 1'b1; m_done = 1'b1; end
          3'd2: if (tmr_cnt == cmp_pri && !m_done) begin nxt = 1'b0; m_done = 1'b1; end
          3'd3: if (tmr_cnt == cmp_pri) nxt = !m_pin;
          3'd4, 3'd5: begin
            if (!m_pin && tmr_cnt == cmp_pri && !m_done) nxt = 1'b1;
            else if (m_pin && tmr_cnt == cmp_sec) begin
              nxt = 1'b0;
              if (m_mode == 3'd4) m_done = 1'b1;
            end
          end
          3'd6, 3'd7: begin
            if (tmr_period_hit) begin m_duty = cmp_sec; nxt = (cmp_sec != 0); end
            else if (tmr_cnt == m_duty) nxt = 1'b0;
          end
          default: ;
        endcase
      end
      if (m_mode == 3'd7 && !fault_n) m_flt = 1'b1;
      if (m_mode == 3'd7 && m_flt) nxt = 1'b0;
      case (m_mode)
        3'd1: ir = nxt && !m_pin;
        3'd2, 3'd4, 3'd5: ir = !nxt && m_pin;
        3'd3: ir = (nxt != m_pin);
        3'd7: ir = ffall;
        default: ir = 1'b0;
      endcase
    end
    m_pin = nxt;
    m_irq = ir;
  endtask

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; tmr_en = 1; tmr_period_hit = 0; gpio_level = 1; fault_n = 1;
    tmr_cnt = 0; cmp_pri = 0; cmp_sec = 0; mode_sel = 3'd0;
    repeat (3) tick();
    chk("R1 reset pin=gpio", pin_out, 1);
    chk("R1 reset irq", irq, 0);
    chk("R9 reset flag", fault_flag, 0);
    chk("R8 reset tmr_clr", tmr_clr, 0);
    rst_n = 1; tick();
    gpio_level = 0; #1;
    chk("R1 gpio follows", pin_out, 0);

    // R3 active-low one-shot
    mode_sel = 3'd1; cmp_pri = 5; tmr_cnt = 0; tick();
    chk("R2 entry 001", pin_out, 0);
    tmr_cnt = 5; tick();
    chk("R3 rise", pin_out, 1); chk("R3 irq", irq, 1);
    tmr_cnt = 6; tick();
    chk("R3 irq one cycle", irq, 0);
    tmr_cnt = 5; tick();
    chk("R3 once pin", pin_out, 1); chk("R3 once irq", irq, 0);

    // R2 toggle keeps the shown level
    mode_sel = 3'd0; gpio_level = 0; tick();
    chk("R1 off pin", pin_out, 0); chk("R1 off irq", irq, 0);
    mode_sel = 3'd3; cmp_pri = 3; tmr_cnt = 0; tick();
    chk("R2 entry 011 keeps", pin_out, 0);
    tmr_cnt = 3; tick();
    chk("R5 rise", pin_out, 1); chk("R5 rise irq", irq, 1);
    tmr_cnt = 4; tick();
    chk("R5 irq clears", irq, 0);
    tmr_cnt = 3; tick();
    chk("R5 fall", pin_out, 0); chk("R5 fall irq", irq, 1);

    // R10 stopped timer
    tmr_en = 0; tick();
    chk("R10 hold pin", pin_out, 0); chk("R10 no irq", irq, 0);
    tick();
    chk("R10 hold pin again", pin_out, 0);

    // R4 active-high one-shot
    tmr_en = 1; mode_sel = 3'd2; cmp_pri = 2; tmr_cnt = 0; tick();
    chk("R2 entry 010", pin_out, 1);
    tmr_cnt = 2; tick();
    chk("R4 fall", pin_out, 0); chk("R4 irq", irq, 1);
    tmr_cnt = 0; tick(); tmr_cnt = 2; tick();
    chk("R4 once", pin_out, 0); chk("R4 once irq", irq, 0);

    // R6 delayed one-shot
    mode_sel = 3'd4; cmp_pri = 2; cmp_sec = 4; tmr_cnt = 0; tick();
    chk("R2 entry 100", pin_out, 0);
    tmr_cnt = 2; tick();
    chk("R6 rise", pin_out, 1); chk("R6 rise no irq", irq, 0);
    tmr_cnt = 4; tick();
    chk("R6 fall", pin_out, 0); chk("R6 fall irq", irq, 1);
    tmr_cnt = 2; tick();
    chk("R6 once", pin_out, 0);

    // R7 continuous pulse
    mode_sel = 3'd5; tmr_cnt = 0; tick();
    chk("R2 entry 101", pin_out, 0);
    tmr_cnt = 2; tick(); chk("R7 rise", pin_out, 1);
    tmr_cnt = 4; tick(); chk("R7 fall", pin_out, 0); chk("R7 irq", irq, 1);
    tmr_cnt = 2; tick(); chk("R7 repeat", pin_out, 1);
    tmr_period_hit = 1; #1;
    chk("R8 no clr outside pwm", tmr_clr, 0);
    tmr_period_hit = 0;

    // R8 PWM
    mode_sel = 3'd6; cmp_pri = 0; cmp_sec = 3; tmr_cnt = 0; tick();
    chk("R2 entry 110 zero", pin_out, 0);
    tmr_period_hit = 1; #1;
    chk("R8 clr", tmr_clr, 1);
    tick();
    chk("R8 period set", pin_out, 1); chk("R8 no irq", irq, 0);
    tmr_period_hit = 0; tmr_cnt = 3; tick();
    chk("R8 duty clear", pin_out, 0); chk("R8 no irq fall", irq, 0);
    cmp_sec = 0; tmr_period_hit = 1; tmr_cnt = 1; tick();
    chk("R8 zero duty", pin_out, 0);
    tmr_period_hit = 0;

    // R9 fault
    mode_sel = 3'd7; cmp_pri = 5; cmp_sec = 3; tmr_cnt = 0; tick();
    chk("R2 entry 111 nonzero", pin_out, 1);
    fault_n = 0; tick();
    chk("R9 forced low", pin_out, 0); chk("R9 flag", fault_flag, 1); chk("R9 irq", irq, 1);
    tick();
    chk("R9 irq once", irq, 0); chk("R9 flag holds", fault_flag, 1);
    fault_n = 1; tmr_period_hit = 1; tick();
    chk("R9 sticky pin", pin_out, 0); chk("R9 sticky flag", fault_flag, 1);
    tmr_period_hit = 0; mode_sel = 3'd6; tick();
    chk("R9 flag cleared", fault_flag, 0); chk("R2 re-entry pwm", pin_out, 1);

    // Random phase against the reference
    rst_n = 0; mode_sel = 3'd0; tick(); tick();
    mdl_reset();
    rst_n = 1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 29) == 0) mode_sel = 3'($urandom_range(0, 7));
      tmr_en         = ($urandom_range(0, 7) != 0);
      tmr_cnt        = W'($urandom_range(0, 7));
      tmr_period_hit = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) cmp_pri = W'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) cmp_sec = W'($urandom_range(0, 7));
      gpio_level     = 1'($urandom_range(0, 1));
      fault_n        = ($urandom_range(0, 19) != 0);
      @(posedge clk);
      mdl_edge();
      #1;
      chk(tag_of(m_mode), pin_out, (m_mode == 3'd0) ? gpio_level : m_pin);
      chk(tag_of(m_mode), irq, m_irq);
      chk("R9 flag", fault_flag, m_flt);
      chk("R8 clr", tmr_clr, (m_mode[2:1] == 2'b11) && tmr_period_hit);
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule